// File: doc/BRIEF.md
# MDIO Management Command Controller

This block lets a host reach the management registers of an Ethernet PHY through a two-wire serial management link (MDC clock, bidirectional MDIO data). The host sees three 16-bit registers on a small write/read bus. It loads the value to send into a write-data register. It then writes a command word that carries the PHY address, the register address and one of two request bits. The request bit stays set while the serial frame is on the wire and drops back to zero on its own when the frame is done. Software polls that bit to learn when a transfer has finished.

A frame is 64 MDC periods long. MDC comes from the system clock through a programmable half-period divider. The block drives MDIO while MDC is low and samples it as MDC rises. During the turnaround and data field of a read, it gives up the line so the PHY can answer. A read that nobody answers returns all ones, because the idle bus floats high.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, all three registers read 0x0000, MDC is low and the MDIO output enable is low. MDC stays low whenever no frame is in progress.
- R2: The command register is at offset 0x20, the read-data register at 0x24 and the write-data register at 0x28. In the command register, bits 12:8 hold the PHY address and bits 4:0 the PHY register address, and both read back as written. Other offsets read 0.
- R3: Writing 1 to command bit 14 starts a write and writing 1 to bit 13 starts a read. The chosen bit reads 1 from the cycle after the command write for exactly 128 x DIV_HALF clock cycles, then reads 0.
- R4: A write frame, MSB first, is 32 ones, 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10, then the 16 bits of the write-data register. The output enable stays high for all 64 bits.
- R5: A read frame carries 32 ones, 01, opcode 10, the PHY address and the register address with the output enable high. The output enable is low for the last 18 bit times, which are the turnaround and the data.
- R6: When a read finishes, the 16 bits sampled in bit times 48 to 63 (MSB first) appear at offset 0x24. If the PHY does not drive the line, the result is 0xFFFF. The read-data register changes at no other time.
- R7: MDC is high for exactly DIV_HALF clock cycles and low for at least DIV_HALF cycles, and exactly DIV_HALF inside a frame. MDIO changes only as MDC falls or when a frame starts.
- R8: A command write while a frame is in progress is ignored. The fields read back unchanged, the running frame is not disturbed and no second frame follows.
- R9: A command with both bits 14 and 13 set runs a write. Only bit 14 reads back as 1.
- R10: A command write with neither request bit set updates the address fields and starts no frame.
- R11: The write-data register can be written and read back at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostAddr | input | 8 | Register offset for host access |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Register value at hostAddr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Serial data driven toward the PHY |
| mdioOe | output | 1 | Output enable for mdioOut |
| mdioIn | input | 1 | Serial data from the PHY (pulled high when undriven) |

## Verification
The in-line assertions check these on every cycle: MDC stays low while idle, MDC holds between divider ticks, MDIO moves only on a shift strobe, the address fields stay frozen while busy, read data stays put except at frame end, and at most one operation flag is set. Only the bench's scenarios can show the following. Exact frame contents are checked by a PHY model that captures bits on MDC rising edges. The model also checks that the line is released from the turnaround onward, that the busy window lasts exactly 128 half-periods, that data is returned with and without a responding PHY, and that a command issued mid-frame leaves no trace.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // Command register bit positions (host-visible encoding)
  localparam int CMD_WR_BIT  = 14;
  localparam int CMD_RD_BIT  = 13;
  localparam int CMD_PHY_LSB = 8;

  // Strobes from the sequencer to the register/shift datapath
  typedef struct packed {
    logic shiftOut;  // advance transmit shifter (MDC falling)
    logic sampleIn;  // capture one receive bit (MDC rising)
    logic finish;    // last bit time ended
  } mdioStrb_t;
endpackage

// File: rtl/mdio_seq_ctrl.sv
module mdio_seq_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_HALF     = 4,
  parameter int FRAME_LEN    = 64,
  parameter int OE_OFF_BIT   = 46,
  parameter int RX_FIRST_BIT = 48
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      opRead,
  output logic      busy,
  output logic      mdc,
  output logic      mdioOe,
  output mdioStrb_t strb
);
  localparam int DIV_W = $clog2(DIV_HALF + 1);
  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_HALF - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] OE_OFF   = CNT_W'(OE_OFF_BIT);
  localparam logic [CNT_W-1:0] RX_FIRST = CNT_W'(RX_FIRST_BIT);

  logic             busyR;
  logic             mdcR;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             tick;
  logic             lastBit;

  assign tick    = busyR && (divCnt == DIV_LAST);
  assign lastBit = (bitCnt == BIT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR  <= 1'b0;
      mdcR   <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (startReq) begin
      busyR  <= 1'b1;
      mdcR   <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (busyR) begin
      if (tick) begin
        divCnt <= '0;
        mdcR   <= ~mdcR;
        if (mdcR) begin
          if (lastBit) busyR <= 1'b0;
          else         bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.shiftOut = tick && mdcR && !lastBit;
    strb.finish   = tick && mdcR && lastBit;
    strb.sampleIn = tick && !mdcR && opRead && (bitCnt >= RX_FIRST);
  end

  assign busy   = busyR;
  assign mdc    = mdcR;
  assign mdioOe = busyR && !(opRead && (bitCnt >= OE_OFF));

  // R1: management clock parked low outside a frame
  p_mdc_idle_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busyR |-> !mdcR);

  // R7: MDC only moves on a divider tick
  p_mdc_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busyR && !tick) |=> $stable(mdcR));

  // R3: completion strobe ends the busy window
  p_finish_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !busyR);
endmodule

// File: rtl/mdio_reg_dp.sv
module mdio_reg_dp
  import mdio_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter int PHY_AW       = 5,
  parameter int REG_AW       = 5,
  parameter int PREAMBLE_LEN = 32,
  parameter int FRAME_LEN    = 64,
  parameter int CMD_OFS      = 'h20,
  parameter int RDAT_OFS     = 'h24,
  parameter int WDAT_OFS     = 'h28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              busy,
  input  mdioStrb_t         strb,
  input  logic              mdioIn,
  output logic              startReq,
  output logic              opRead,
  output logic              mdioOut
);
  logic [PHY_AW-1:0]    phyAddr;
  logic [REG_AW-1:0]    regAddr;
  logic [DATA_W-1:0]    wrData;
  logic [DATA_W-1:0]    rdData;
  logic [DATA_W-1:0]    rxShift;
  logic [FRAME_LEN-1:0] txShift;
  logic [FRAME_LEN-1:0] frameNext;
  logic [DATA_W-1:0]    cmdView;
  logic                 opWr;
  logic                 opRd;
  logic                 cmdHit;
  logic                 reqWr;
  logic                 reqRd;

  assign cmdHit   = hostWrEn && (hostAddr == ADDR_W'(CMD_OFS));
  assign reqWr    = hostWrData[CMD_WR_BIT];
  assign reqRd    = hostWrData[CMD_RD_BIT];
  assign startReq = cmdHit && !busy && (reqWr || reqRd);

  // Frame image, MSB goes out first
  assign frameNext = {{PREAMBLE_LEN{1'b1}}, 2'b01,
                      reqWr ? 2'b01 : 2'b10,
                      hostWrData[CMD_PHY_LSB +: PHY_AW],
                      hostWrData[REG_AW-1:0],
                      reqWr ? 2'b10 : 2'b11,
                      reqWr ? wrData : {DATA_W{1'b1}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyAddr <= '0;
      regAddr <= '0;
      wrData  <= '0;
      rdData  <= '0;
      rxShift <= '0;
      txShift <= '0;
      opWr    <= 1'b0;
      opRd    <= 1'b0;
    end else begin
      if (hostWrEn && (hostAddr == ADDR_W'(WDAT_OFS)))
        wrData <= hostWrData;
      if (cmdHit && !busy) begin
        phyAddr <= hostWrData[CMD_PHY_LSB +: PHY_AW];
        regAddr <= hostWrData[REG_AW-1:0];
      end
      if (startReq) begin
        opWr    <= reqWr;
        opRd    <= !reqWr;
        txShift <= frameNext;
      end else if (strb.shiftOut) begin
        txShift <= {txShift[FRAME_LEN-2:0], 1'b0};
      end
      if (strb.sampleIn)
        rxShift <= {rxShift[DATA_W-2:0], mdioIn};
      if (strb.finish) begin
        opWr <= 1'b0;
        opRd <= 1'b0;
        if (opRd) rdData <= rxShift;
      end
    end
  end

  always_comb begin
    cmdView = '0;
    cmdView[CMD_WR_BIT] = opWr;
    cmdView[CMD_RD_BIT] = opRd;
    cmdView[CMD_PHY_LSB +: PHY_AW] = phyAddr;
    cmdView[REG_AW-1:0] = regAddr;
  end

  always_comb begin
    if (hostAddr == ADDR_W'(CMD_OFS))       hostRdData = cmdView;
    else if (hostAddr == ADDR_W'(RDAT_OFS)) hostRdData = rdData;
    else if (hostAddr == ADDR_W'(WDAT_OFS)) hostRdData = wrData;
    else                                    hostRdData = '0;
  end

  assign opRead  = opRd;
  assign mdioOut = txShift[FRAME_LEN-1];

  // R8: address fields frozen while a frame runs
  p_fields_locked_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(phyAddr) && $stable(regAddr)));

  // R7: serial output moves only on a shift strobe
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.shiftOut) |=> $stable(mdioOut));

  // R6: read result only updated at frame end
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> $stable(rdData));

  // R9: never a read and a write at once
  p_single_op_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({opWr, opRd}));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_HALF     = 4,
  parameter int ADDR_W       = 8,
  parameter int PHY_AW       = 5,
  parameter int REG_AW       = 5,
  parameter int PREAMBLE_LEN = 32,
  parameter int CMD_OFS      = 'h20,
  parameter int RDAT_OFS     = 'h24,
  parameter int WDAT_OFS     = 'h28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic [15:0]       hostWrData,
  output logic [15:0]       hostRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  localparam int DATA_W    = 16;
  localparam int TA_BIT    = PREAMBLE_LEN + 4 + PHY_AW + REG_AW;
  localparam int DATA_BIT  = TA_BIT + 2;
  localparam int FRAME_LEN = DATA_BIT + DATA_W;

  logic      busy;
  logic      startReq;
  logic      opRead;
  mdioStrb_t strb;

  mdio_seq_ctrl #(
    .DIV_HALF    (DIV_HALF),
    .FRAME_LEN   (FRAME_LEN),
    .OE_OFF_BIT  (TA_BIT),
    .RX_FIRST_BIT(DATA_BIT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .opRead  (opRead),
    .busy    (busy),
    .mdc     (mdc),
    .mdioOe  (mdioOe),
    .strb    (strb)
  );

  mdio_reg_dp #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PHY_AW      (PHY_AW),
    .REG_AW      (REG_AW),
    .PREAMBLE_LEN(PREAMBLE_LEN),
    .FRAME_LEN   (FRAME_LEN),
    .CMD_OFS     (CMD_OFS),
    .RDAT_OFS    (RDAT_OFS),
    .WDAT_OFS    (WDAT_OFS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .hostAddr  (hostAddr),
    .hostWrEn  (hostWrEn),
    .hostWrData(hostWrData),
    .hostRdData(hostRdData),
    .busy      (busy),
    .strb      (strb),
    .mdioIn    (mdioIn),
    .startReq  (startReq),
    .opRead    (opRead),
    .mdioOut   (mdioOut)
  );
endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb;
  localparam int HALF = 4;
  localparam logic [7:0] A_CMD = 8'h20, A_RD = 8'h24, A_WR = 8'h28;
  localparam logic [4:0] MODEL_PHY = 5'd1;

  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic mdc, mdioOut, mdioOe, mdioIn;

  int tests = 0, fails = 0;
  bit wdFired = 0;

  always #5 clk = ~clk;

  mdio_mgmt_ctrl #(.DIV_HALF(HALF)) u_dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn));

  function automatic logic [15:0] phyVal(input logic [4:0] r);
    return {r, ~r, r, 1'b1};
  endfunction

  function automatic logic [63:0] expFrame(input bit isWr, input logic [4:0] p,
                                           input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, isWr ? 2'b01 : 2'b10, p, r,
            isWr ? 2'b10 : 2'b11, isWr ? d : 16'hFFFF};
  endfunction

  // PHY model: captures on MDC rise, answers reads to MODEL_PHY
  logic [5:0]  rise = '0;
  logic [63:0] cap = '0, oeCap = '0;
  logic        respond = 1'b0;
  logic [15:0] modelVal;
  assign modelVal = phyVal(cap[22:18]);
  assign mdioIn = (respond && rise >= 6'd48) ? modelVal[4'(6'd63 - rise)] : 1'b1;

  always @(posedge mdc) begin
    cap[6'd63 - rise]   <= mdioOe ? mdioOut : 1'b1;
    oeCap[6'd63 - rise] <= mdioOe;
    if (rise == 6'd46) respond <= (cap[29:28] == 2'b10) && (cap[27:23] == MODEL_PHY);
    else if (rise == 6'd63) respond <= 1'b0;
    rise <= rise + 6'd1;
  end

  // MDC phase-length monitor (R7)
  int mdcErr = 0, hiLen = 0, loLen = 100;
  logic prevMdc = 1'b0;
  always @(negedge clk) begin
    if (prevMdc && !mdc) begin if (hiLen != HALF) mdcErr++; hiLen = 0; end
    if (!prevMdc && mdc) begin if (loLen < HALF) mdcErr++; loLen = 0; end
    if (mdc) hiLen++; else loLen++;
    prevMdc = mdc;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    hostAddr = a; #1;
    v = hostRdData;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    hostAddr = A_CMD; #1;
    while ((hostRdData[14] || hostRdData[13]) && n < 5000) begin
      n++;
      @(posedge clk); #1;
    end
  endtask

  task automatic doTxn(input bit isWr, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] d);
    int n;
    logic [15:0] v, expRd;
    logic [63:0] ef;
    if (isWr) wrReg(A_WR, d);
    wrReg(A_CMD, (isWr ? 16'h4000 : 16'h2000) | {3'b0, p, 3'b0, r});
    waitIdle(n);
    check(n == 128 * HALF, "R3 busy length", 64'(n), 64'(128 * HALF));
    repeat (3) @(posedge clk);
    ef = expFrame(isWr, p, r, d);
    if (isWr) begin
      check(cap == ef, "R4 write frame", cap, ef);
      check(oeCap == '1, "R4 write output enable", oeCap, '1);
    end else begin
      check(cap[63:18] == ef[63:18], "R5 read header", 64'(cap[63:18]), 64'(ef[63:18]));
      check(oeCap == {{46{1'b1}}, 18'b0}, "R5 line released", oeCap, {{46{1'b1}}, 18'b0});
      rdReg(A_RD, v);
      expRd = (p == MODEL_PHY) ? phyVal(r) : 16'hFFFF;
      check(v == expRd, "R6 read data", 64'(v), 64'(expRd));
    end
    rdReg(A_CMD, v);
    check(v == {3'b0, p, 3'b0, r}, "R3 R2 command after done", 64'(v), 64'({3'b0, p, 3'b0, r}));
  endtask

  task automatic runAll();
    logic [15:0] v, keepRd;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    // R1 reset state
    rdReg(A_CMD, v); check(v == 16'h0, "R1 command reset", 64'(v), 0);
    rdReg(A_RD, v);  check(v == 16'h0, "R1 read-data reset", 64'(v), 0);
    rdReg(A_WR, v);  check(v == 16'h0, "R1 write-data reset", 64'(v), 0);
    check(!mdc && !mdioOe, "R1 idle pins", {62'b0, mdc, mdioOe}, 0);
    rdReg(8'h30, v); check(v == 16'h0, "R2 unmapped offset", 64'(v), 0);
    // R10 fields without request
    wrReg(A_CMD, 16'h0305);
    rdReg(A_CMD, v); check(v == 16'h0305, "R10 R2 field readback", 64'(v), 64'h0305);
    repeat (50) @(posedge clk); #1;
    check(!mdc && !mdioOe, "R10 no frame started", {62'b0, mdc, mdioOe}, 0);
    // R11 write-data readback
    wrReg(A_WR, 16'h5A5A);
    rdReg(A_WR, v); check(v == 16'h5A5A, "R11 write-data readback", 64'(v), 64'h5A5A);
    // Directed transfers
    doTxn(1'b1, 5'd1, 5'd4, 16'h01E1);
    doTxn(1'b0, 5'd1, 5'd2, 16'h0);
    doTxn(1'b0, 5'd3, 5'd2, 16'h0);          // R6 no responder
    doTxn(1'b1, 5'd31, 5'd31, 16'hFFFF);
    doTxn(1'b0, 5'd1, 5'd0, 16'h0);
    // R8 command during busy is ignored
    rdReg(A_RD, keepRd);
    wrReg(A_WR, 16'hBEEF);
    wrReg(A_CMD, 16'h4107);
    repeat (30) @(posedge clk);
    wrReg(A_CMD, 16'h2309);
    rdReg(A_CMD, v); check(v == 16'h4107, "R8 fields during busy", 64'(v), 64'h4107);
    waitIdle(n);
    repeat (3) @(posedge clk);
    check(cap == expFrame(1'b1, 5'd1, 5'd7, 16'hBEEF), "R8 frame undisturbed", cap,
          expFrame(1'b1, 5'd1, 5'd7, 16'hBEEF));
    repeat (200) @(posedge clk); #1;
    check(!mdc && !mdioOe, "R8 no second frame", {62'b0, mdc, mdioOe}, 0);
    rdReg(A_RD, v); check(v == keepRd, "R8 read data untouched", 64'(v), 64'(keepRd));
    rdReg(A_CMD, v); check(v == 16'h0107, "R8 fields after done", 64'(v), 64'h0107);
    // R9 both request bits
    wrReg(A_WR, 16'h1357);
    wrReg(A_CMD, 16'h6205);
    hostAddr = A_CMD; #1;
    check(hostRdData[14:13] == 2'b10, "R9 write wins", 64'(hostRdData[14:13]), 64'b10);
    waitIdle(n);
    repeat (3) @(posedge clk);
    check(cap == expFrame(1'b1, 5'd2, 5'd5, 16'h1357), "R9 write frame", cap,
          expFrame(1'b1, 5'd2, 5'd5, 16'h1357));
    // Random transfers
    for (int i = 0; i < 16; i++) begin
      bit isWr = 1'($urandom % 2);
      logic [4:0] p = ($urandom % 3 == 0) ? 5'($urandom) : MODEL_PHY;
      doTxn(isWr, p, 5'($urandom), 16'($urandom));
    end
    check(mdcErr == 0, "R7 MDC phase lengths", 64'(mdcErr), 0);
  endtask

  initial begin
    fork
      runAll();
      begin repeat (150000) @(posedge clk); wdFired = 1; end
    join_any
    disable fork;
    if (wdFired) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule